// File: doc/BRIEF.md
# Word Rotator with Carry Capture

This block keeps one data word in a register and rotates it toward the least significant end by a count chosen on each cycle. Bits that leave the bottom come back in at the top, so the word loses nothing. A separate carry register, outside the rotation loop, receives the last bit that left the bottom, which is bit n−1 of the word as it was before the step.

The word can be treated as a narrow half-width value (16 bits by default) or as the full width (32 bits by default). In narrow mode only the low half rotates and the upper half of the register is kept at zero. A command input requests a rotation. In level mode a step happens on every cycle in which the command is high. In edge mode a step happens once for each low-to-high change of the command.

A synchronous load writes a new word and wins over a rotation in the same cycle. A count beyond the selected width raises an error output and blocks the step.

Top module: `word_rotator`

## Requirements
- R1: In wide mode (`wide_mode`=1) with a valid nonzero count n, one step sets the word to the old word rotated right by n across all 32 bits; n=32 leaves the word unchanged.
- R2: In narrow mode (`wide_mode`=0) a step rotates only bits 15..0 right by n, and bits 31..16 read zero after the step; a narrow load also zero-fills bits 31..16.
- R3: After a step the carry holds bit n−1 of the word before the step (for n=4 on 16'hABCD the result is 16'hDABC with carry 1).
- R4: A count of 0 leaves both the word and the carry unchanged.
- R5: `count_err` is high, combinationally, whenever the count exceeds 16 in narrow mode or 32 in wide mode; while it is high a requested step changes neither word nor carry.
- R6: With `pulse_mode`=0 a step is taken on every clock edge at which `cmd` is high.
- R7: With `pulse_mode`=1 exactly one step is taken per rising edge of `cmd`; holding `cmd` high takes no further steps.
- R8: `load_en` writes the word on the next edge, leaves the carry alone and takes priority over a step requested in the same cycle; a rising `cmd` edge that coincides with a load is consumed without a step.
- R9: Reset (`rst_n` low) clears the word, the carry and the command edge history.
- R10: With `cmd` low and no load, word and carry hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write `load_data` into the word |
| load_data | input | 32 | Word to load |
| wide_mode | input | 1 | 1: full width, 0: half width |
| count | input | 6 | Rotate distance n, unsigned |
| cmd | input | 1 | Rotation request |
| pulse_mode | input | 1 | 0: step every cycle cmd is high, 1: step on rising edge only |
| word_q | output | 32 | Current word |
| carry_q | output | 1 | Captured carry bit |
| count_err | output | 1 | Count exceeds the limit of the selected width |

## Verification
The two functions that can meet in one cycle are the load and a rotation request. The bench raises `cmd` from low to high in edge mode on the same cycle as `load_en`, with a count and carry value that would make any rotation visible. It is judged correct when the word equals the loaded value, the carry keeps its earlier value, and the following cycles with `cmd` still high take no step because the edge was used up.

// File: rtl/wrot_pkg.sv
package wrot_pkg;
    localparam int unsigned WROT_WORD_W = 32;

    typedef enum logic {
        EXEC_LEVEL = 1'b0,
        EXEC_EDGE  = 1'b1
    } exec_mode_e;
endpackage

// File: rtl/wrot_trigger.sv
module wrot_trigger
    import wrot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    input  logic pulse_mode,
    output logic fire
);
    logic prev_d, prev_q;
    exec_mode_e mode;

    always_comb begin
        mode   = exec_mode_e'(pulse_mode);
        prev_d = cmd;
        if (mode == EXEC_EDGE) fire = cmd && !prev_q;
        else                   fire = cmd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R7: in edge mode a held command never fires again
    p_edge_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && prev_q) |-> !fire);
    // R6: in level mode a high command always fires
    p_level_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && cmd) |-> fire);
endmodule

// File: rtl/wrot_shifter.sv
module wrot_shifter #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned HALF_W = WORD_W / 2,
    parameter int unsigned CNT_W  = $clog2(WORD_W) + 1
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic              wide_mode,
    input  logic [CNT_W-1:0]  count,
    output logic [WORD_W-1:0] rot_word,
    output logic              rot_carry
);
    localparam int unsigned IDX_W = $clog2(WORD_W);

    logic [WORD_W-1:0] full_rot;
    logic [HALF_W-1:0] half_rot;
    logic [IDX_W-1:0]  out_idx;

    always_comb begin
        // duplicate then shift: the low part is the rotated word
        full_rot  = WORD_W'({word_in, word_in} >> count);
        half_rot  = HALF_W'({word_in[HALF_W-1:0], word_in[HALF_W-1:0]} >> count);
        out_idx   = IDX_W'(count - 1'b1);
        rot_carry = word_in[out_idx];
        rot_word  = wide_mode ? full_rot : {{(WORD_W-HALF_W){1'b0}}, half_rot};
    end
endmodule

// File: rtl/word_rotator.sv
module word_rotator #(
    parameter int unsigned WORD_W = wrot_pkg::WROT_WORD_W,
    parameter int unsigned CNT_W  = $clog2(WORD_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_data,
    input  logic              wide_mode,
    input  logic [CNT_W-1:0]  count,
    input  logic              cmd,
    input  logic              pulse_mode,
    output logic [WORD_W-1:0] word_q,
    output logic              carry_q,
    output logic              count_err
);
    localparam int unsigned HALF_W = WORD_W / 2;
    localparam int unsigned IDX_W  = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              carry;
    } rot_state_t;

    rot_state_t st_d, st_q;
    logic              fire;
    logic              do_rot;
    logic [CNT_W-1:0]  limit;
    logic [WORD_W-1:0] rot_word;
    logic              rot_carry;

    wrot_trigger u_trigger (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .pulse_mode (pulse_mode),
        .fire       (fire)
    );

    wrot_shifter #(
        .WORD_W (WORD_W),
        .HALF_W (HALF_W),
        .CNT_W  (CNT_W)
    ) u_shifter (
        .word_in   (st_q.word),
        .wide_mode (wide_mode),
        .count     (count),
        .rot_word  (rot_word),
        .rot_carry (rot_carry)
    );

    always_comb begin
        limit     = wide_mode ? CNT_W'(WORD_W) : CNT_W'(HALF_W);
        count_err = count > limit;
        do_rot    = fire && !count_err && (count != '0);
        st_d      = st_q;
        if (load_en) begin
            st_d.word = wide_mode ? load_data
                                  : {{(WORD_W-HALF_W){1'b0}}, load_data[HALF_W-1:0]};
        end else if (do_rot) begin
            st_d.word  = rot_word;
            st_d.carry = rot_carry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_q  = st_q.word;
    assign carry_q = st_q.carry;

    // independent reference forms for the checks below
    logic [WORD_W-1:0] chk_rot;
    logic              chk_bit;
    always_comb begin
        chk_rot = (word_q >> count) | (word_q << (WORD_W - 32'(count)));
        chk_bit = word_q[IDX_W'(count - 1'b1)];
    end

    p_wide_rot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && do_rot && wide_mode) |=> (word_q == $past(chk_rot)));
    p_narrow_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_mode && (load_en || do_rot)) |=> (word_q[WORD_W-1:HALF_W] == '0));
    p_carry_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && do_rot) |=> (carry_q == $past(chk_bit)));
    p_zero_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && count == '0) |=> ($stable(word_q) && $stable(carry_q)));
    p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && count_err) |=> ($stable(word_q) && $stable(carry_q)));
    p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && wide_mode) |=> (word_q == $past(load_data) && $stable(carry_q)));
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !cmd) |=> ($stable(word_q) && $stable(carry_q)));
endmodule

// File: tb/word_rotator_test.sv
module word_rotator_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_en;
    logic [31:0] load_data;
    logic        wide_mode;
    logic [5:0]  count;
    logic        cmd;
    logic        pulse_mode;
    logic [31:0] word_q;
    logic        carry_q;
    logic        count_err;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_word;
    logic        m_carry;
    logic        m_prev;

    always #4 clk = ~clk;

    word_rotator uut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
        .wide_mode(wide_mode), .count(count), .cmd(cmd), .pulse_mode(pulse_mode),
        .word_q(word_q), .carry_q(carry_q), .count_err(count_err)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // advance one clock; update the model from the requirements, compare
    task automatic tick(string tag);
        logic        fire;
        logic [5:0]  lim;
        logic [15:0] w16;
        lim  = wide_mode ? 6'd32 : 6'd16;
        fire = pulse_mode ? (cmd && !m_prev) : cmd;
        m_prev = cmd;
        if (load_en) begin
            m_word = wide_mode ? load_data : {16'h0, load_data[15:0]};
        end else if (fire && count != 0 && count <= lim) begin
            m_carry = m_word[count - 1];
            if (wide_mode) begin
                m_word = (m_word >> count) | (m_word << (32 - count));
            end else begin
                w16 = m_word[15:0];
                w16 = (w16 >> count) | (w16 << (16 - count));
                m_word = {16'h0, w16};
            end
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " word"}, word_q, m_word);
        check({tag, " carry"}, {31'h0, carry_q}, {31'h0, m_carry});
    endtask

    task automatic do_load(string tag, logic wide, logic [31:0] val);
        wide_mode = wide; load_data = val; load_en = 1'b1;
        tick(tag);
        load_en = 1'b0;
    endtask

    task automatic t_reset;
        check("R9 reset word", word_q, 32'h0);
        check("R9 reset carry", {31'h0, carry_q}, 32'h0);
        check("R5 reset err", {31'h0, count_err}, 32'h0);
    endtask

    task automatic t_example16;
        pulse_mode = 1'b1; cmd = 1'b0; count = 6'd4;
        do_load("R2 narrow load", 1'b0, 32'hFFFF_ABCD);
        check("R2 upper zero on load", word_q, 32'h0000_ABCD);
        tick("R10 idle");
        cmd = 1'b1;
        tick("R3 example");
        check("R3 example word", word_q, 32'h0000_DABC);
        check("R3 example carry", {31'h0, carry_q}, 32'h1);
        tick("R7 held");
        tick("R7 held");
        check("R7 no repeat", word_q, 32'h0000_DABC);
        cmd = 1'b0; tick("R7 low");
        cmd = 1'b1; tick("R7 second edge");
        check("R7 second edge", word_q, 32'h0000_CDAB);
        cmd = 1'b0; tick("R10 idle");
    endtask

    task automatic t_continuous;
        pulse_mode = 1'b0; count = 6'd1;
        do_load("R8 wide load", 1'b1, 32'h8000_0001);
        cmd = 1'b1;
        for (int i = 0; i < 4; i++) tick("R6 level step");
        check("R6 after four", word_q, 32'h1800_0000);
        count = 6'd5;
        for (int i = 0; i < 3; i++) tick("R1 wide n5");
        cmd = 1'b0; tick("R10 idle");
    endtask

    task automatic t_full_and_zero;
        pulse_mode = 1'b0;
        do_load("R8 wide load", 1'b1, 32'h8765_4321);
        count = 6'd32; cmd = 1'b1;
        tick("R1 n32");
        check("R1 n32 word", word_q, 32'h8765_4321);
        check("R3 n32 carry", {31'h0, carry_q}, 32'h1);
        count = 6'd0;
        tick("R4 n0");
        check("R4 n0 word", word_q, 32'h8765_4321);
        check("R4 n0 carry", {31'h0, carry_q}, 32'h1);
        cmd = 1'b0;
        do_load("R2 narrow load", 1'b0, 32'h0000_0001);
        count = 6'd16; cmd = 1'b1;
        tick("R2 n16");
        check("R2 n16 word", word_q, 32'h0000_0001);
        check("R3 n16 carry", {31'h0, carry_q}, 32'h0);
        cmd = 1'b0;
    endtask

    task automatic t_errors;
        pulse_mode = 1'b0;
        do_load("R2 narrow load", 1'b0, 32'h0000_1234);
        count = 6'd17; #1;
        check("R5 narrow 17 err", {31'h0, count_err}, 32'h1);
        cmd = 1'b1;
        tick("R5 narrow blocked");
        check("R5 narrow held", word_q, 32'h0000_1234);
        wide_mode = 1'b1; #1;
        check("R5 wide 17 ok", {31'h0, count_err}, 32'h0);
        count = 6'd33; #1;
        check("R5 wide 33 err", {31'h0, count_err}, 32'h1);
        tick("R5 wide blocked");
        check("R5 wide held", word_q, 32'h0000_1234);
        cmd = 1'b0; count = 6'd1;
    endtask

    task automatic t_narrow_from_wide;
        pulse_mode = 1'b0;
        do_load("R8 wide load", 1'b1, 32'hFFFF_0003);
        wide_mode = 1'b0; count = 6'd1; cmd = 1'b1;
        tick("R2 narrow step");
        check("R2 upper cleared", word_q, 32'h0000_8001);
        cmd = 1'b0;
    endtask

    task automatic t_load_collide;
        pulse_mode = 1'b1; wide_mode = 1'b1; count = 6'd3;
        do_load("R8 setup", 1'b1, 32'h0000_00F8);
        cmd = 1'b1; tick("R8 edge"); cmd = 1'b0; tick("R8 low");
        check("R8 setup carry", {31'h0, carry_q}, 32'h0);
        load_data = 32'h0000_000F; load_en = 1'b1; cmd = 1'b1;
        tick("R8 collide");
        load_en = 1'b0;
        check("R8 load wins", word_q, 32'h0000_000F);
        check("R8 carry kept", {31'h0, carry_q}, 32'h0);
        tick("R8 edge used");
        check("R8 edge consumed", word_q, 32'h0000_000F);
        cmd = 1'b0; tick("R10 idle");
    endtask

    task automatic t_reset_again;
        pulse_mode = 1'b0; count = 6'd2; cmd = 1'b1;
        tick("R6 pre-reset");
        rst_n = 1'b0; #1;
        check("R9 word cleared", word_q, 32'h0);
        check("R9 carry cleared", {31'h0, carry_q}, 32'h0);
        m_word = '0; m_carry = 1'b0; m_prev = 1'b0;
        cmd = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; load_en = 1'b0; load_data = '0; wide_mode = 1'b0;
        count = '0; cmd = 1'b0; pulse_mode = 1'b0;
        m_word = '0; m_carry = 1'b0; m_prev = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_example16();
        t_continuous();
        t_full_and_zero();
        t_errors();
        t_narrow_from_wide();
        t_load_collide();
        t_reset_again();
        t_example16();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule